// File: doc/BRIEF.md
# Dual Timer/Counter with Split Mode

This block holds two 16-bit timer/counters, called timer A and timer B. Each is made of a low byte and a high byte. A microcontroller core reaches them through a small register port. Every timer advances once per machine cycle, or once per sampled falling edge on its own count pin. A gate pin can be added to the enable, so that a timer counts only while an external level holds it open. Each timer works in one of four modes: a 13-bit counter (a 5-bit prescaler under the high byte), a 16-bit counter, an 8-bit counter that reloads itself, and a split mode.

In split mode the two bytes of timer A become two separate 8-bit timers. The low byte keeps timer A's own run bit and flag. The high byte counts machine cycles under timer B's run bit and sets timer B's flag. While timer A is in split mode, timer B is halted. Each overflow sets a sticky flag that software clears. An overflow that raises timer B's flag also gives a one-cycle strobe, for use by a baud-rate or interrupt stage.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0 (mode, control, and the four count bytes), both flags are 0 and the strobe is low.
- R2: The register map is: address 0 = mode, 1 = control, 2 = A low, 3 = A high, 4 = B low, 5 = B high. Unused addresses read 0. In the mode register, bits [3:0] configure A and bits [7:4] configure B. Inside a nibble, bits [1:0] are the mode (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split), bit 2 selects pin counting (1) over machine-cycle counting (0), and bit 3 enables the gate. In the control register, bit 0 = run A, bit 1 = run B, bit 2 = flag A, bit 3 = flag B.
- R3: With the gate off, a timer advances once per `tick` cycle while its run bit is 1, and holds its value while its run bit is 0.
- R4: With the gate on, a timer also needs its gate pin high (pin 0 for A, pin 1 for B). When the pin is low, the count holds.
- R5: In 13-bit mode, low bits [4:0] count ticks and bits [7:5] keep their value. A carry out of bits [4:0] increments the high byte. Wrapping from high byte 0xFF with low bits 0x1F clears both and sets the flag.
- R6: In 16-bit mode, the pair counts as one value, and the step from 0xFFFF to 0x0000 sets the flag.
- R7: In 8-bit reload mode, the low byte counts. When it steps past 0xFF, it is loaded from the high byte and the flag is set. The high byte does not change.
- R8: When A is in split mode, A's low byte counts under run A and sets flag A. A's high byte counts machine cycles under run B and sets flag B. Timer B holds.
- R9: Timer B in split mode of its own holds its count, even while run B is set.
- R10: In pin-counting mode, the count pin is sampled only in `tick` cycles. An increment needs a 1 sample followed by a 0 sample, so a pulse that falls between ticks and rises again before the next tick is not counted.
- R11: Flags stay set until software writes the control register. A bus write to a count byte wins over counting in that same cycle. Every event that sets flag B drives `t1_ovf_pulse` high for exactly the following cycle, together with the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 2 | External count inputs, bit 0 for A, bit 1 for B |
| gate_pin | input | 2 | External gate levels, bit 0 for A, bit 1 for B |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| ovf_flag | output | 2 | Overflow flags, bit 0 for A, bit 1 for B |
| t1_ovf_pulse | output | 1 | One-cycle strobe when flag B is set |

## Verification
The bench builds the block with the default prescaler width of 5. This puts a 13-bit wrap only two ticks away once the bytes are preloaded near their limits. Because the count bytes can be written, every overflow, reload and split-mode carry is reached in a handful of ticks, not thousands. On every clock, a behavioural reference model is compared against the flags, the strobe and the byte selected on the read port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    M_13B   = 2'd0,
    M_16B   = 2'd1,
    M_RELD  = 2'd2,
    M_SPLIT = 2'd3
  } tmr_mode_e;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_T0L  = 3'd2;
  localparam logic [2:0] A_T0H  = 3'd3;
  localparam logic [2:0] A_T1L  = 3'd4;
  localparam logic [2:0] A_T1H  = 3'd5;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_smp
    logic samp_q;
    logic samp_n;

    always_comb begin
      samp_n = samp_q;
      if (tick) samp_n = pin[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp_q <= 1'b0;
      else        samp_q <= samp_n;
    end

    // falling edge seen between two consecutive tick samples
    assign fall[i] = tick & samp_q & ~pin[i];
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  tmr_mode_e         mode,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] hi,
  input  logic              ev_main,
  input  logic              ev_hi3,
  output logic [BYTE_W-1:0] lo_n,
  output logic [BYTE_W-1:0] hi_n,
  output logic              ovf_main,
  output logic              ovf_hi3
);
  always_comb begin
    lo_n     = lo;
    hi_n     = hi;
    ovf_main = 1'b0;
    ovf_hi3  = 1'b0;
    unique case (mode)
      M_13B: if (ev_main) begin
        if (&lo[PRE_W-1:0]) begin
          lo_n[PRE_W-1:0] = '0;
          hi_n            = hi + 8'd1;
          ovf_main        = &hi;
        end else begin
          lo_n[PRE_W-1:0] = lo[PRE_W-1:0] + 1'b1;
        end
      end
      M_16B: if (ev_main) begin
        {hi_n, lo_n} = {hi, lo} + 16'd1;
        ovf_main     = &{hi, lo};
      end
      M_RELD: if (ev_main) begin
        if (&lo) begin
          lo_n     = hi;
          ovf_main = 1'b1;
        end else begin
          lo_n = lo + 8'd1;
        end
      end
      M_SPLIT: begin
        if (ev_main) begin
          lo_n     = lo + 8'd1;
          ovf_main = &lo;
        end
        if (ev_hi3) begin
          hi_n    = hi + 8'd1;
          ovf_hi3 = &hi;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [1:0] ovf_flag,
  output logic       t1_ovf_pulse
);
  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  logic [7:0] mode_q, mode_n;
  logic [1:0] run_q, run_n, flag_q, flag_n;
  logic [7:0] t0l_q, t0h_q, t1l_q, t1h_q;
  logic [7:0] t0l_n, t0h_n, t1l_n, t1h_n;
  logic       pulse_q, pulse_n;

  logic [1:0] fall;
  tmr_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .pin(cnt_pin), .fall(fall)
  );

  tmr_mode_e m0, m1;
  assign m0 = tmr_mode_e'(mode_q[1:0]);
  assign m1 = tmr_mode_e'(mode_q[5:4]);

  logic en0, en1, ev0, ev0h, ev1;
  assign en0  = run_q[0] & (~mode_q[3] | gate_pin[0]);
  assign ev0  = en0 & (mode_q[2] ? fall[0] : tick);
  assign ev0h = tick & run_q[1];
  assign en1  = run_q[1] & (~mode_q[7] | gate_pin[1]) &
                (m0 != M_SPLIT) & (m1 != M_SPLIT);
  assign ev1  = en1 & (mode_q[6] ? fall[1] : tick);

  logic [7:0] c0l, c0h, c1l, c1h;
  logic       o0m, o0h, o1m, o1h;

  tmr_count #(.PRE_W(PRE_W)) u_cnt0 (
    .mode(m0), .lo(t0l_q), .hi(t0h_q), .ev_main(ev0), .ev_hi3(ev0h),
    .lo_n(c0l), .hi_n(c0h), .ovf_main(o0m), .ovf_hi3(o0h)
  );
  tmr_count #(.PRE_W(PRE_W)) u_cnt1 (
    .mode(m1), .lo(t1l_q), .hi(t1h_q), .ev_main(ev1), .ev_hi3(1'b0),
    .lo_n(c1l), .hi_n(c1h), .ovf_main(o1m), .ovf_hi3(o1h)
  );

  logic set0, set1;
  assign set0 = o0m;
  assign set1 = o1m | o0h | o1h;

  always_comb begin
    mode_n  = mode_q;
    run_n   = run_q;
    flag_n  = flag_q;
    t0l_n   = c0l;
    t0h_n   = c0h;
    t1l_n   = c1l;
    t1h_n   = c1h;
    if (wr_en) begin
      unique case (addr)
        A_MODE: mode_n = wdata;
        A_CTRL: begin
          run_n  = wdata[1:0];
          flag_n = wdata[3:2];
        end
        A_T0L:  t0l_n = wdata;
        A_T0H:  t0h_n = wdata;
        A_T1L:  t1l_n = wdata;
        A_T1H:  t1h_n = wdata;
        default: ;
      endcase
    end
    flag_n  = flag_n | {set1, set0};
    pulse_n = set1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mode_q  <= '0;
      run_q   <= '0;
      flag_q  <= '0;
      t0l_q   <= '0;
      t0h_q   <= '0;
      t1l_q   <= '0;
      t1h_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      run_q   <= run_n;
      flag_q  <= flag_n;
      t0l_q   <= t0l_n;
      t0h_q   <= t0h_n;
      t1l_q   <= t1l_n;
      t1h_q   <= t1h_n;
      pulse_q <= pulse_n;
    end
  end

  always_comb begin
    unique case (addr)
      A_MODE:  rdata = mode_q;
      A_CTRL:  rdata = {4'd0, flag_q, run_q};
      A_T0L:   rdata = t0l_q;
      A_T0H:   rdata = t0h_q;
      A_T1L:   rdata = t1l_q;
      A_T1H:   rdata = t1h_q;
      default: rdata = '0;
    endcase
  end

  assign ovf_flag     = flag_q;
  assign t1_ovf_pulse = pulse_q;

  logic wr_t0l, wr_t1;
  assign wr_t0l = wr_en & (addr == A_T0L);
  assign wr_t1  = wr_en & ((addr == A_T1L) | (addr == A_T1H));

  // R3
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!run_q[0] && !wr_t0l) |=> $stable(t0l_q));

  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode_q[3] && !gate_pin[0] && !wr_t0l) |=> $stable(t0l_q));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (m0 == M_RELD && o0m && !wr_t0l) |=> (t0l_q == $past(t0h_q)));

  // R9
  t1_split_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (m1 == M_SPLIT && !wr_t1) |=> $stable({t1h_q, t1l_q}));

  // R11
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    t1_ovf_pulse |-> ovf_flag[1]);
endmodule

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [1:0] ovf_flag;
  logic       t1_ovf_pulse;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  string cur_req = "R1";

  tmr_pair dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ovf_flag(ovf_flag), .t1_ovf_pulse(t1_ovf_pulse)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int m_mode, m_run0, m_run1, m_f0, m_f1, m_pulse;
  int m_al, m_ah, m_bl, m_bh, m_s0, m_s1, m_rc;

  function automatic int m_read(input int a);
    case (a)
      0: return m_mode;
      1: return m_run0 + 2 * m_run1 + 4 * m_f0 + 8 * m_f1;
      2: return m_al;
      3: return m_ah;
      4: return m_bl;
      5: return m_bh;
      default: return 0;
    endcase
  endfunction

  task automatic step_timer(input int md, input bit ev, inout int lo, inout int hi,
                            output bit ovf);
    int v;
    ovf = 0;
    if (!ev) return;
    case (md)
      0: if (lo % 32 == 31) begin
           lo = lo - 31;
           if (hi == 255) begin hi = 0; ovf = 1; end else hi = hi + 1;
         end else lo = lo + 1;
      1: begin
           v = hi * 256 + lo + 1;
           if (v == 65536) begin v = 0; ovf = 1; end
           hi = v / 256; lo = v % 256;
         end
      2: if (lo == 255) begin lo = hi; ovf = 1; end else lo = lo + 1;
      default: begin
           if (lo == 255) ovf = 1;
           lo = (lo + 1) % 256;
         end
    endcase
  endtask

  initial begin
    m_mode = 0; m_run0 = 0; m_run1 = 0; m_f0 = 0; m_f1 = 0; m_pulse = 0;
    m_al = 0; m_ah = 0; m_bl = 0; m_bh = 0; m_s0 = 0; m_s1 = 0; m_rc = 0;
  end

  always @(posedge clk) begin
    bit f0, f1, ev0, ev1, s0, s1, sh;
    int m0, m1;
    if (!rst_n) begin
      m_mode = 0; m_run0 = 0; m_run1 = 0; m_f0 = 0; m_f1 = 0; m_pulse = 0;
      m_al = 0; m_ah = 0; m_bl = 0; m_bh = 0; m_s0 = 0; m_s1 = 0; m_rc = 0;
    end else if (m_rc < 2) begin
      m_rc++;
    end else begin
      f0 = tick && m_s0 == 1 && !cnt_pin[0];
      f1 = tick && m_s1 == 1 && !cnt_pin[1];
      if (tick) begin m_s0 = cnt_pin[0]; m_s1 = cnt_pin[1]; end
      m0 = m_mode % 4;
      m1 = (m_mode / 16) % 4;
      ev0 = m_run0 == 1 && (((m_mode / 8) % 2 == 0) || gate_pin[0]) &&
            (((m_mode / 4) % 2 == 1) ? f0 : tick);
      ev1 = m_run1 == 1 && (((m_mode / 128) % 2 == 0) || gate_pin[1]) &&
            m0 != 3 && m1 != 3 && (((m_mode / 64) % 2 == 1) ? f1 : tick);
      step_timer(m0, ev0, m_al, m_ah, s0);
      sh = 0;
      if (m0 == 3 && tick && m_run1 == 1) begin
        if (m_ah == 255) sh = 1;
        m_ah = (m_ah + 1) % 256;
      end
      step_timer(m1, ev1, m_bl, m_bh, s1);
      if (wr_en) begin
        case (addr)
          0: m_mode = wdata;
          1: begin
               m_run0 = wdata[0]; m_run1 = wdata[1];
               m_f0 = wdata[2]; m_f1 = wdata[3];
             end
          2: m_al = wdata;
          3: m_ah = wdata;
          4: m_bl = wdata;
          5: m_bh = wdata;
          default: ;
        endcase
      end
      if (s0) m_f0 = 1;
      if (s1 || sh) m_f1 = 1;
      m_pulse = (s1 || sh) ? 1 : 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always begin
    @(posedge clk);
    #2;
    if (chk_on) begin
      chk({cur_req, " flags"}, ovf_flag, m_f0 + 2 * m_f1);
      chk({cur_req, " strobe"}, t1_ovf_pulse, m_pulse);
      chk({cur_req, " rdata"}, rdata, m_read(addr));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[2:0]; wdata = d[7:0]; tick = 1'b0;
  endtask

  task automatic cycles(input int n, input bit t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; tick = t;
    end
  endtask

  task automatic cstep(input bit t, input bit c);
    @(negedge clk);
    wr_en = 1'b0; tick = t; cnt_pin[0] = c;
  endtask

  task automatic rd(input string req, input int a, input int exp);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; addr = a[2:0];
    @(posedge clk);
    #2;
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cycles(4, 1'b0);
    chk_on = 1'b1;

    // R1: reset state
    cur_req = "R1";
    for (int a = 0; a < 8; a++) rd("R1 reset read", a, 0);
    chk("R1 flags", ovf_flag, 0);
    chk("R1 strobe", t1_ovf_pulse, 0);

    // R6, R2: 16-bit wrap on A
    cur_req = "R6";
    wr(0, 8'h01); wr(2, 8'hFD); wr(3, 8'hFF); wr(1, 8'h01);
    cycles(4, 1'b1);
    rd("R6 A low", 2, 8'h01);
    rd("R6 A high", 3, 8'h00);
    chk("R6 flag A", ovf_flag, 2'b01);

    // R3: run bit cleared, ticks ignored
    cur_req = "R3";
    wr(1, 8'h04);
    cycles(3, 1'b1);
    rd("R3 hold", 2, 8'h01);
    rd("R2 ctrl", 1, 8'h04);

    // R5: 13-bit prescaler carry
    cur_req = "R5";
    wr(0, 8'h00); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h01);
    cycles(2, 1'b1);
    rd("R5 A low", 2, 8'hE0);
    rd("R5 A high", 3, 8'h00);
    rd("R5 ctrl", 1, 8'h05);

    // R7, R11: B reload and strobe
    cur_req = "R7";
    wr(1, 8'h00);
    wr(0, 8'h20); wr(4, 8'hFE); wr(5, 8'hF0); wr(1, 8'h02);
    cycles(3, 1'b1);
    rd("R7 B low", 4, 8'hF1);
    rd("R7 B high", 5, 8'hF0);
    rd("R11 ctrl", 1, 8'h0A);

    // R4: gate pin
    cur_req = "R4";
    wr(1, 8'h00);
    wr(0, 8'h09); wr(2, 8'h10); wr(3, 8'h00); wr(1, 8'h01);
    gate_pin[0] = 1'b0;
    cycles(4, 1'b1);
    rd("R4 gate low", 2, 8'h10);
    gate_pin[0] = 1'b1;
    cycles(3, 1'b1);
    rd("R4 gate high", 2, 8'h13);
    gate_pin[0] = 1'b0;

    // R10: pin counting
    cur_req = "R10";
    wr(0, 8'h05); wr(2, 8'h00);
    cstep(1, 1); cstep(1, 1); cstep(1, 0); cstep(1, 0);
    cstep(1, 1); cstep(1, 0); cstep(1, 0);
    rd("R10 edges", 2, 8'h02);
    cstep(1, 1); cstep(0, 0); cstep(0, 1); cstep(1, 1);
    rd("R10 between ticks", 2, 8'h02);

    // R8: A split, B halted
    cur_req = "R8";
    wr(1, 8'h00);
    wr(0, 8'h03); wr(2, 8'hFE); wr(3, 8'hFE); wr(4, 8'h05); wr(5, 8'h00);
    wr(1, 8'h03);
    cycles(2, 1'b1);
    rd("R8 A low", 2, 8'h00);
    rd("R8 A high", 3, 8'h00);
    rd("R8 B held", 4, 8'h05);
    rd("R8 ctrl", 1, 8'h0F);

    // R9: B in its own split mode
    cur_req = "R9";
    wr(1, 8'h00);
    wr(0, 8'h30); wr(4, 8'h22); wr(1, 8'h02);
    cycles(4, 1'b1);
    rd("R9 B held", 4, 8'h22);
    rd("R9 ctrl", 1, 8'h02);

    // R11: flags clear by write
    cur_req = "R11";
    wr(1, 8'h0C);
    cycles(1, 1'b0);
    chk("R11 flags set", ovf_flag, 2'b11);
    wr(1, 8'h00);
    cycles(1, 1'b0);
    rd("R11 cleared", 1, 8'h00);
    chk("R11 flags clear", ovf_flag, 2'b00);

    cycles(2, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule